// File: doc/BRIEF.md
# Strobed Pseudo-Random Bit Source

This block feeds serial test data to a Manchester line encoder that runs from a 100 MHz system clock. An internal counter divides the system clock by `DIVIDER` (10 by default, giving 10 Mbit/s). It raises a bit-enable strobe for a single clock once per bit period. It also drives a square bit clock in step with that period.

Each strobe advances an `N`-stage linear feedback shift register by one step. The stage that leaves the register is presented as the NRZ serial bit. A companion index counter reports the position of the current bit within the maximal-length burst of 2^N − 1 bits. Between strobes both outputs hold, so the downstream encoder can sample them on the strobe cycle or at any time in the bit period.

Top module: `prbs_burst_src`

## Requirements
- R1: While reset (synchronous, active high) is applied, after the first clock edge, `ser_bit` is 1, `burst_idx` is 0, `bit_stb` is 0 and `bit_clk` is 1. This is the all-ones register seed.
- R2: `bit_stb` is high for exactly one clock in every `DIVIDER` clocks. The first pulse falls in the `DIVIDER`-th cycle after reset is released.
- R3: In each bit period `bit_clk` is high for the first `DIVIDER/2` cycles (rounded down), counting from the cycle after a strobe, and low for the rest.
- R4: `ser_bit` and `burst_idx` change only on a clock edge at which `bit_stb` is high.
- R5: The register shifts toward its top stage, and `ser_bit` is the top stage (stage N). The new bottom stage is the XOR of the tap stages. For N = 4 the taps are stages 4 and 3 (x^4 + x^3 + 1). Other N from 3 to 16 use a fixed maximal-length tap set.
- R6: `burst_idx` increases by one on every strobe. After the strobe that finds it at 2^N − 2, it wraps to 0.
- R7: The serial sequence repeats with a period of exactly 2^N − 1 strobes. After 2^N − 1 strobes from reset, `burst_idx` is 0 and `ser_bit` is back to 1.
- R8: The register never reaches all zeros, so `ser_bit` is never 0 for more than N − 1 consecutive strobes.
- R9: Applying reset in the middle of a run restores the R1 state and restarts the strobe timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | output | 1 | One-cycle strobe, once per bit period |
| bit_clk | output | 1 | Square clock at the bit rate, high in the first half of the period |
| ser_bit | output | 1 | Pseudo-random NRZ serial bit |
| burst_idx | output | N | Index of the current bit within the 2^N − 1 bit burst |

## Verification
A wrong tap or a corrupt register stage shows at `ser_bit` within at most N strobes, which is 40 clocks by default. The scoreboard compares every strobe against an independent model of the register, so the mismatch is caught at the first wrong bit. A divider miscount shows as a strobe gap other than `DIVIDER`, or as a wrong count of high `bit_clk` cycles, at the first bit period. An index that is out of step with the register shows either as a nonzero `burst_idx` at the strobe where the sequence returns to its seed, or as a sequence that does not repeat after 2^N − 1 strobes.

// File: rtl/prbs_burst_src.sv
module prbs_burst_src #(
  parameter int DIVIDER = 10,
  parameter int N       = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic         bit_stb,
  output logic         bit_clk,
  output logic         ser_bit,
  output logic [N-1:0] burst_idx
);
  localparam int CW = (DIVIDER > 2) ? $clog2(DIVIDER) : 1;
  localparam int IDX_LAST = (2 ** N) - 2;

  function automatic logic [31:0] tap_mask(input int n);
    logic [31:0] m;
    m = '0;
    case (n)
      3:  begin m[2] = 1'b1; m[1] = 1'b1; end
      4:  begin m[3] = 1'b1; m[2] = 1'b1; end
      5:  begin m[4] = 1'b1; m[2] = 1'b1; end
      6:  begin m[5] = 1'b1; m[4] = 1'b1; end
      7:  begin m[6] = 1'b1; m[5] = 1'b1; end
      8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
      9:  begin m[8] = 1'b1; m[4] = 1'b1; end
      10: begin m[9] = 1'b1; m[6] = 1'b1; end
      11: begin m[10] = 1'b1; m[8] = 1'b1; end
      12: begin m[11] = 1'b1; m[10] = 1'b1; m[9] = 1'b1; m[3] = 1'b1; end
      13: begin m[12] = 1'b1; m[11] = 1'b1; m[10] = 1'b1; m[7] = 1'b1; end
      14: begin m[13] = 1'b1; m[12] = 1'b1; m[11] = 1'b1; m[1] = 1'b1; end
      15: begin m[14] = 1'b1; m[13] = 1'b1; end
      16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  localparam logic [31:0] TAPS_ALL = tap_mask(N);
  localparam logic [N-1:0] TAPS = TAPS_ALL[N-1:0];

  logic [CW-1:0] div_cnt;
  logic [N-1:0]  lfsr;
  logic          fb;

  assign bit_stb = (div_cnt == CW'(DIVIDER - 1));
  assign bit_clk = (div_cnt < CW'(DIVIDER / 2));
  assign fb      = ^(lfsr & TAPS);
  assign ser_bit = lfsr[N-1];

  always_ff @(posedge clk) begin
    if (rst)          div_cnt <= '0;
    else if (bit_stb) div_cnt <= '0;
    else              div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr      <= '1;
      burst_idx <= '0;
    end else if (bit_stb) begin
      lfsr      <= {lfsr[N-2:0], fb};
      burst_idx <= (burst_idx == N'(IDX_LAST)) ? '0 : burst_idx + 1'b1;
    end
  end
endmodule

module prbs_burst_src_chk #(
  parameter int DIVIDER = 10,
  parameter int N       = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_stb,
  input logic         bit_clk,
  input logic         ser_bit,
  input logic [N-1:0] burst_idx,
  input logic [N-1:0] lfsr
);
  localparam int GW = $clog2(DIVIDER + 1) + 1;
  localparam int IDX_LAST = (2 ** N) - 2;

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)          gap <= '0;
    else if (bit_stb) gap <= '0;
    else              gap <= gap + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (burst_idx == '0 && ser_bit && !bit_stb && bit_clk));

  assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> gap == GW'(DIVIDER - 1));

  assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  assert_bitclk_phase_R3: assert property (@(posedge clk) disable iff (rst)
    bit_clk == (gap < GW'(DIVIDER / 2)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> ($stable(ser_bit) && $stable(burst_idx)));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && burst_idx != N'(IDX_LAST)) |=> burst_idx == $past(burst_idx) + 1'b1);

  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && burst_idx == N'(IDX_LAST)) |=> burst_idx == '0);

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
    burst_idx <= N'(IDX_LAST));

  assert_seed_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && burst_idx == N'(IDX_LAST)) |=> lfsr == '1);

  assert_no_lockup_R8: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

bind prbs_burst_src prbs_burst_src_chk #(.DIVIDER(DIVIDER), .N(N)) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_clk(bit_clk),
  .ser_bit(ser_bit), .burst_idx(burst_idx), .lfsr(lfsr)
);

// File: tb/test_prbs_burst_src.sv
module test_prbs_burst_src;
  localparam int DIVIDER = 10;
  localparam int N = 4;
  localparam int PERIOD = (2 ** N) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb, bit_clk, ser_bit;
  logic [N-1:0] burst_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [N:0] expq[$];

  prbs_burst_src #(.DIVIDER(DIVIDER), .N(N)) i_prbs_burst_src (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_clk(bit_clk),
    .ser_bit(ser_bit), .burst_idx(burst_idx)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: reference register model, x^4 + x^3 + 1, shift toward top stage
  task automatic push_expected(input int n);
    logic [N-1:0] s = '1;
    int idx = 0;
    for (int i = 0; i < n; i++) begin
      s = {s[N-2:0], s[3] ^ s[2]};
      idx = (idx == PERIOD - 1) ? 0 : idx + 1;
      expq.push_back({s[N-1], N'(idx)});
    end
  endtask

  // Monitor
  bit rst_prev = 1'b0;
  bit prev_stb = 1'b0;
  int gap = 0, hi = 0, step = 0, zrun = 0;
  logic last_ser;
  logic [N-1:0] last_idx;
  logic hist[0:63];

  always @(negedge clk) begin
    if (rst) begin
      if (rst_prev) begin
        chk(ser_bit == 1'b1, "R1 ser_bit", int'(ser_bit), 1);
        chk(burst_idx == '0, "R1 burst_idx", int'(burst_idx), 0);
        chk(bit_stb == 1'b0, "R1 bit_stb", int'(bit_stb), 0);
        chk(bit_clk == 1'b1, "R1 bit_clk", int'(bit_clk), 1);
      end
      gap = 0; hi = 0; step = 0; zrun = 0; prev_stb = 1'b0;
      last_ser = 1'b1; last_idx = '0; hist[0] = 1'b1;
    end else begin
      gap++;
      if (bit_clk) hi++;
      if (prev_stb) begin
        logic [N:0] e;
        if (expq.size() == 0) begin
          chk(1'b0, "R5 scoreboard empty", 0, 1);
        end else begin
          e = expq.pop_front();
          chk(ser_bit == e[N], "R5 ser_bit", int'(ser_bit), int'(e[N]));
          chk(burst_idx == e[N-1:0], "R6 burst_idx", int'(burst_idx), int'(e[N-1:0]));
        end
        step++;
        if (step < 64) hist[step] = ser_bit;
        if (step >= PERIOD && step < 64)
          chk(hist[step] == hist[step-PERIOD], "R7 repeat", int'(hist[step]), int'(hist[step-PERIOD]));
        if (step == PERIOD) begin
          chk(burst_idx == '0, "R7 idx at period", int'(burst_idx), 0);
          chk(ser_bit == 1'b1, "R7 seed bit", int'(ser_bit), 1);
        end
        zrun = ser_bit ? 0 : zrun + 1;
        chk(zrun <= N - 1, "R8 zero run", zrun, N - 1);
      end else begin
        chk(ser_bit == last_ser, "R4 ser_bit hold", int'(ser_bit), int'(last_ser));
        chk(burst_idx == last_idx, "R4 burst_idx hold", int'(burst_idx), int'(last_idx));
      end
      if (bit_stb) begin
        chk(gap == DIVIDER, "R2 strobe gap", gap, DIVIDER);
        chk(hi == DIVIDER / 2, "R3 bit_clk high cycles", hi, DIVIDER / 2);
        gap = 0; hi = 0;
      end
      prev_stb = bit_stb;
      last_ser = ser_bit;
      last_idx = burst_idx;
    end
    rst_prev = rst;
  end

  initial begin
    push_expected(40);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    while (step < 40) @(negedge clk);
    // R9: reset in the middle of a run
    @(posedge clk);
    #1 rst = 1'b1;
    expq.delete();
    push_expected(20);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    while (step < 20) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R9 scoreboard drained", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", step, 20);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule